// File: doc/BRIEF.md
# Key-Gated Register Write Protection Unit

This unit sits between a simple register bus and a peripheral's register file and decides, write by write, whether the addressed register may change. Software arms it through a mode register. The mode register holds three protection enables: one for the general configuration registers, one for the interrupt register group and one for the control register. These enables only move when the same bus write also carries a fixed 24-bit unlock key. A separate reporting-mode bit is not key-gated.

Every blocked write is logged in a status register. The log holds a sticky violation flag, the word offset of the refused register and a two-bit error type naming the protection group that refused it. The first violation of a series raises a one-cycle software-error interrupt pulse. The reporting mode picks what happens to later violations in the same series: either each one overwrites the source and type, or the first record is kept. Reading the status register returns its content and clears it, which closes the series. The register file itself only sees the per-write allow signal.

The bus has separate read and write address ports, so a status read and a blocked write can occur in the same cycle. Read data is registered and appears one cycle after the read strobe.

Top module: `regwp_guard`

## Requirements
- R1: After reset all three enables, the reporting-mode bit and the whole status record are zero. `bus_rdata`, `sw_err_irq` and `wr_allow` are low.
- R2: A write to the mode register (byte offset 0xE4) changes the enables only if bits 31:8 of the write data equal 0x535044. In that case the global/configuration enable takes bit 0, the interrupt-group enable takes bit 1 and the control enable takes bit 2. Any other key leaves all three enables unchanged.
- R3: The reporting-mode bit takes bit 4 of every write to the mode register, whatever the key field holds.
- R4: A mode-register read returns the enables in bits 0, 1 and 2 and the reporting-mode bit in bit 4. All other bits read as zero, including the key field 31:8. Read data appears in the cycle after the read strobe and is zero when no mode or status read was made.
- R5: With the global enable set, a write to any configuration register gives `wr_allow` low, logs error type 1 and does not update the target. A configuration register is any offset other than control (0x00), the interrupt group (0x10 to 0x1C), mode and status.
- R6: With the interrupt enable set, writes to 0x10 to 0x1C are refused with error type 2. With the control enable set, writes to 0x00 are refused with error type 3. Each group is affected only by its own enable.
- R7: The status register reads as: sticky flag in bit 0, source word offset (address bits 7:2) in bits 13:8, and error type in bits 17:16.
- R8: With the reporting-mode bit at 0, every violation in a series overwrites the stored source and type.
- R9: With the reporting-mode bit at 1, later violations in a series leave the stored source and type unchanged.
- R10: `sw_err_irq` pulses high for one cycle, in the cycle after the write, only for the first violation of a series, in both reporting modes.
- R11: A status read returns the content from before the read and clears the record. A violation in the same cycle as that read starts a new series: it is recorded as first and raises the pulse.
- R12: Writes to the mode and status registers are never refused and never drive `wr_allow`. Writes to the status register change nothing. Reads are never blocked. `wr_allow` is high only for an unrefused write to a target register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | 8 | Write byte address |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_raddr | input | 8 | Read byte address |
| bus_rdata | output | 32 | Registered read data for the mode and status registers |
| wr_allow | output | 1 | The current write may update its target register |
| sw_err_irq | output | 1 | One-cycle pulse on the first violation of a series |

## Verification
The two functions that can fall in one cycle are the clearing status read and the logging of a new violation. The bench provokes this by driving a status read on the read port while a refused write sits on the write port in the same cycle. It also repeats the collision in a randomised phase with both reporting modes. The judgement is that the read returns the old record, while the new violation appears afterwards as the first of a fresh series, with the interrupt pulse. A behavioural reference model in the bench predicts allow, read data and pulse on every clock.

// File: rtl/regwp_pkg.sv
package regwp_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int WOFS_W = ADDR_W - 2;
    localparam int KEY_W  = 24;
    localparam int KEY_LSB = DATA_W - KEY_W;
    localparam int NGRP   = 3;

    // mode register bit positions
    localparam int MB_GLOB  = 0;
    localparam int MB_IRQ   = 1;
    localparam int MB_CTRL  = 2;
    localparam int MB_FIRST = 4;

    // status register field positions
    localparam int SB_STICKY = 0;
    localparam int SB_SRC    = 8;
    localparam int SB_TYPE   = 16;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_CFG  = 2'd1,
        ERR_IRQ  = 2'd2,
        ERR_CTRL = 2'd3
    } err_t;

    typedef enum logic [2:0] {
        GRP_CFG,
        GRP_IRQ,
        GRP_CTRL,
        GRP_MODE,
        GRP_STAT
    } grp_t;

    typedef struct packed {
        logic first;
        logic ctrl;
        logic irq;
        logic glob;
    } mode_t;

    typedef struct packed {
        logic              sticky;
        logic [WOFS_W-1:0] src;
        err_t              etype;
    } log_t;

    function automatic err_t grp_err(input int idx);
        case (idx)
            0:       return ERR_CFG;
            1:       return ERR_IRQ;
            default: return ERR_CTRL;
        endcase
    endfunction

endpackage

// File: rtl/regwp_decode.sv
module regwp_decode
    import regwp_pkg::*;
#(
    parameter logic [WOFS_W-1:0] MODE_WOFS = 6'h39,
    parameter logic [WOFS_W-1:0] STAT_WOFS = 6'h3A,
    parameter logic [WOFS_W-1:0] CTRL_WOFS = 6'h00,
    parameter logic [WOFS_W-1:0] IRQ_WLO   = 6'h04,
    parameter logic [WOFS_W-1:0] IRQ_WHI   = 6'h07
) (
    input  logic [ADDR_W-1:0] addr,
    output grp_t              grp,
    output logic [WOFS_W-1:0] wofs
);

    logic [1:0] unused_byte_lane;

    assign wofs             = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];

    always_comb begin
        if (wofs == MODE_WOFS) begin
            grp = GRP_MODE;
        end else if (wofs == STAT_WOFS) begin
            grp = GRP_STAT;
        end else if (wofs == CTRL_WOFS) begin
            grp = GRP_CTRL;
        end else if (wofs >= IRQ_WLO && wofs <= IRQ_WHI) begin
            grp = GRP_IRQ;
        end else begin
            grp = GRP_CFG;
        end
    end

endmodule

// File: rtl/regwp_mode.sv
module regwp_mode
    import regwp_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 24'h535044
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode,
    output logic [DATA_W-1:0] rd_word
);

    mode_t mode_d, mode_q;
    logic  key_ok;
    logic  unused_spare;

    assign key_ok       = (wdata[KEY_LSB +: KEY_W] == KEY);
    assign unused_spare = ^{wdata[KEY_LSB-1:MB_FIRST+1], wdata[MB_FIRST-1:MB_CTRL+1]};

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d.first = wdata[MB_FIRST];
            if (key_ok) begin
                mode_d.glob = wdata[MB_GLOB];
                mode_d.irq  = wdata[MB_IRQ];
                mode_d.ctrl = wdata[MB_CTRL];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        rd_word           = '0;
        rd_word[MB_GLOB]  = mode_q.glob;
        rd_word[MB_IRQ]   = mode_q.irq;
        rd_word[MB_CTRL]  = mode_q.ctrl;
        rd_word[MB_FIRST] = mode_q.first;
    end

    assign mode = mode_q;

endmodule

// File: rtl/regwp_gate.sv
module regwp_gate
    import regwp_pkg::*;
(
    input  logic  wr,
    input  grp_t  grp,
    input  mode_t mode,
    output logic  allow,
    output logic  viol,
    output err_t  etype
);

    logic [NGRP-1:0] en;
    logic [NGRP-1:0] hit;
    logic [NGRP-1:0] blk;
    logic            target;

    assign en  = {mode.ctrl, mode.irq, mode.glob};
    assign hit = {grp == GRP_CTRL, grp == GRP_IRQ, grp == GRP_CFG};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign blk[g] = wr & en[g] & hit[g];
    end

    assign target = |hit;
    assign viol   = |blk;
    assign allow  = wr & target & ~viol;

    always_comb begin
        etype = ERR_NONE;
        for (int g = 0; g < NGRP; g++) begin
            if (blk[g]) begin
                etype = grp_err(g);
            end
        end
    end

endmodule

// File: rtl/regwp_log.sv
module regwp_log
    import regwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol,
    input  err_t              etype,
    input  logic [WOFS_W-1:0] src,
    input  logic              clr,
    input  logic              keep_first,
    output log_t              rec,
    output logic              irq,
    output logic [DATA_W-1:0] rd_word
);

    typedef struct packed {
        log_t rec;
        logic irq;
    } st_t;

    st_t  st_d, st_q;
    logic series_open;

    always_comb begin
        st_d        = st_q;
        st_d.irq    = 1'b0;
        series_open = st_q.rec.sticky & ~clr;
        if (clr) begin
            st_d.rec = '0;
        end
        if (viol) begin
            if (!series_open) begin
                st_d.rec.sticky = 1'b1;
                st_d.rec.src    = src;
                st_d.rec.etype  = etype;
                st_d.irq        = 1'b1;
            end else if (!keep_first) begin
                st_d.rec.src   = src;
                st_d.rec.etype = etype;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_word                      = '0;
        rd_word[SB_STICKY]           = st_q.rec.sticky;
        rd_word[SB_SRC +: WOFS_W]    = st_q.rec.src;
        rd_word[SB_TYPE +: 2]        = st_q.rec.etype;
    end

    assign rec = st_q.rec;
    assign irq = st_q.irq;

endmodule

// File: rtl/regwp_guard.sv
module regwp_guard
    import regwp_pkg::*;
#(
    parameter logic [KEY_W-1:0]  KEY       = 24'h535044,
    parameter logic [WOFS_W-1:0] MODE_WOFS = 6'h39,
    parameter logic [WOFS_W-1:0] STAT_WOFS = 6'h3A,
    parameter logic [WOFS_W-1:0] CTRL_WOFS = 6'h00,
    parameter logic [WOFS_W-1:0] IRQ_WLO   = 6'h04,
    parameter logic [WOFS_W-1:0] IRQ_WHI   = 6'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wr_allow,
    output logic              sw_err_irq
);

    grp_t              wgrp, rgrp;
    logic [WOFS_W-1:0] wofs, rofs;
    mode_t             mode_cur;
    log_t              log_cur;
    logic              viol;
    err_t              etype;
    logic [DATA_W-1:0] mode_word, stat_word;
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic [WOFS_W-1:0] unused_rofs;

    assign unused_rofs = rofs;

    regwp_decode #(
        .MODE_WOFS(MODE_WOFS), .STAT_WOFS(STAT_WOFS), .CTRL_WOFS(CTRL_WOFS),
        .IRQ_WLO(IRQ_WLO), .IRQ_WHI(IRQ_WHI)
    ) u_wdec (
        .addr (bus_waddr),
        .grp  (wgrp),
        .wofs (wofs)
    );

    regwp_decode #(
        .MODE_WOFS(MODE_WOFS), .STAT_WOFS(STAT_WOFS), .CTRL_WOFS(CTRL_WOFS),
        .IRQ_WLO(IRQ_WLO), .IRQ_WHI(IRQ_WHI)
    ) u_rdec (
        .addr (bus_raddr),
        .grp  (rgrp),
        .wofs (rofs)
    );

    regwp_mode #(.KEY(KEY)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && wgrp == GRP_MODE),
        .wdata   (bus_wdata),
        .mode    (mode_cur),
        .rd_word (mode_word)
    );

    regwp_gate u_gate (
        .wr    (bus_wr),
        .grp   (wgrp),
        .mode  (mode_cur),
        .allow (wr_allow),
        .viol  (viol),
        .etype (etype)
    );

    regwp_log u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .viol       (viol),
        .etype      (etype),
        .src        (wofs),
        .clr        (bus_rd && rgrp == GRP_STAT),
        .keep_first (mode_cur.first),
        .rec        (log_cur),
        .irq        (sw_err_irq),
        .rd_word    (stat_word)
    );

    always_comb begin
        rdata_d = '0;
        if (bus_rd) begin
            case (rgrp)
                GRP_MODE: rdata_d = mode_word;
                GRP_STAT: rdata_d = stat_word;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/regwp_guard_chk.sv
module regwp_guard_chk
    import regwp_pkg::*;
#(
    parameter logic [KEY_W-1:0]  KEY       = 24'h535044,
    parameter logic [WOFS_W-1:0] MODE_WOFS = 6'h39,
    parameter logic [WOFS_W-1:0] STAT_WOFS = 6'h3A,
    parameter logic [WOFS_W-1:0] CTRL_WOFS = 6'h00,
    parameter logic [WOFS_W-1:0] IRQ_WLO   = 6'h04,
    parameter logic [WOFS_W-1:0] IRQ_WHI   = 6'h07
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_waddr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_raddr,
    input logic              wr_allow,
    input logic              sw_err_irq,
    input mode_t             mode_s,
    input log_t              log_s
);

    logic [WOFS_W-1:0] cw, cr;
    logic              w_admin, w_cfg, r_stat;

    assign cw      = bus_waddr[ADDR_W-1:2];
    assign cr      = bus_raddr[ADDR_W-1:2];
    assign w_admin = (cw == MODE_WOFS) || (cw == STAT_WOFS);
    assign w_cfg   = !w_admin && cw != CTRL_WOFS && !(cw >= IRQ_WLO && cw <= IRQ_WHI);
    assign r_stat  = bus_rd && cr == STAT_WOFS;

    assert_allow_needs_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |-> bus_wr);

    assert_admin_not_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w_admin) |-> !wr_allow);

    assert_cfg_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w_cfg && mode_s.glob) |-> !wr_allow);

    assert_ctrl_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cw == CTRL_WOFS && mode_s.ctrl) |-> !wr_allow);

    assert_badkey_keeps_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cw == MODE_WOFS && bus_wdata[KEY_LSB +: KEY_W] != KEY)
        |=> $stable({mode_s.glob, mode_s.irq, mode_s.ctrl}));

    assert_first_bit_unkeyed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cw == MODE_WOFS) |=> (mode_s.first == $past(bus_wdata[MB_FIRST])));

    assert_pulse_with_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_err_irq |-> log_s.sticky);

    assert_keep_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s.first && log_s.sticky && !r_stat) |=> ($stable(log_s.src) && $stable(log_s.etype)));

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_stat && !bus_wr) |=> !log_s.sticky);

endmodule

bind regwp_guard regwp_guard_chk #(
    .KEY(KEY), .MODE_WOFS(MODE_WOFS), .STAT_WOFS(STAT_WOFS),
    .CTRL_WOFS(CTRL_WOFS), .IRQ_WLO(IRQ_WLO), .IRQ_WHI(IRQ_WHI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_waddr  (bus_waddr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_raddr  (bus_raddr),
    .wr_allow   (wr_allow),
    .sw_err_irq (sw_err_irq),
    .mode_s     (mode_cur),
    .log_s      (log_cur)
);

// File: tb/tb_regwp_guard.sv
`timescale 1ns/1ps
module tb_regwp_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic        wr_allow;
    logic        sw_err_irq;

    int errs = 0;
    int checks = 0;

    // reference model state
    bit        m_glob, m_irq, m_ctrl, m_first;
    bit        s_sticky;
    int        s_src, s_type;
    bit [31:0] exp_rdata = 0;
    bit        exp_irq = 0;
    string     prev_tag = "R1";

    localparam bit [23:0] KEYV = 24'h535044;
    localparam bit [7:0]  A_MODE = 8'hE4;
    localparam bit [7:0]  A_STAT = 8'hE8;

    always #2.5 clk = ~clk;

    regwp_guard dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_raddr(bus_raddr),
        .bus_rdata(bus_rdata), .wr_allow(wr_allow), .sw_err_irq(sw_err_irq)
    );

    // 0 cfg, 1 irq group, 2 ctrl, 3 mode, 4 status
    function automatic int kind(input bit [7:0] a);
        int w = int'(a >> 2);
        if (w == 'h39) return 3;
        if (w == 'h3A) return 4;
        if (w == 0) return 2;
        if (w >= 4 && w <= 7) return 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit model_allow(input bit w, input bit [7:0] a);
        int k = kind(a);
        if (!w || k > 2) return 0;
        if (k == 0 && m_glob) return 0;
        if (k == 1 && m_irq) return 0;
        if (k == 2 && m_ctrl) return 0;
        return 1;
    endfunction

    task automatic model_step(input bit w, input bit [7:0] wa, input bit [31:0] wd,
                              input bit r, input bit [7:0] ra);
        bit [31:0] rv = 0;
        int  k = kind(wa);
        bit  v = 0;
        int  t = 0;
        bit  clr, open_s;
        if (r && kind(ra) == 3)
            rv = {27'd0, m_first, 1'b0, m_ctrl, m_irq, m_glob};
        if (r && kind(ra) == 4)
            rv = 32'(s_sticky) | (32'(s_src) << 8) | (32'(s_type) << 16);
        if (w) begin
            if (k == 0 && m_glob) begin v = 1; t = 1; end
            if (k == 1 && m_irq)  begin v = 1; t = 2; end
            if (k == 2 && m_ctrl) begin v = 1; t = 3; end
        end
        clr = r && kind(ra) == 4;
        open_s = s_sticky && !clr;
        exp_irq = 0;
        if (clr) begin s_sticky = 0; s_src = 0; s_type = 0; end
        if (v) begin
            if (!open_s) begin
                s_sticky = 1; s_src = int'(wa >> 2); s_type = t; exp_irq = 1;
            end else if (!m_first) begin
                s_src = int'(wa >> 2); s_type = t;
            end
        end
        if (w && k == 3) begin
            m_first = wd[4];
            if (wd[31:8] == KEYV) begin
                m_glob = wd[0]; m_irq = wd[1]; m_ctrl = wd[2];
            end
        end
        exp_rdata = rv;
    endtask

    task automatic cyc(input bit w, input bit [7:0] wa, input bit [31:0] wd,
                       input bit r, input bit [7:0] ra, input string tag);
        bit ea;
        @(negedge clk);
        chk(bus_rdata == exp_rdata, prev_tag, "rdata", bus_rdata, exp_rdata);
        chk(sw_err_irq == exp_irq, prev_tag, "irq", 32'(sw_err_irq), 32'(exp_irq));
        bus_wr = w; bus_waddr = wa; bus_wdata = wd; bus_rd = r; bus_raddr = ra;
        #1;
        ea = model_allow(w, wa);
        chk(wr_allow == ea, tag, "wr_allow", 32'(wr_allow), 32'(ea));
        @(posedge clk);
        model_step(w, wa, wd, r, ra);
        prev_tag = tag;
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d, input string tag);
        cyc(1, a, d, 0, 8'h00, tag);
    endtask

    task automatic rd(input bit [7:0] a, input string tag);
        cyc(0, 8'h00, 32'h0, 1, a, tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 8'h00, 32'h0, 0, 8'h00, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog R1 act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        bit [7:0] pool [7] = '{8'h00, 8'h10, 8'h1C, 8'h20, 8'h40, A_MODE, A_STAT};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through the ports
        idle("R1");
        rd(A_MODE, "R1");
        rd(A_STAT, "R1");
        idle("R1");

        // unprotected config write goes through
        wr(8'h20, 32'hAAAA, "R12");

        // R2/R3: wrong key, enables stay, first bit still taken
        wr(A_MODE, 32'h12345617, "R2");
        rd(A_MODE, "R3");
        wr(8'h20, 32'h1, "R2");
        // R2: right key, global only
        wr(A_MODE, {KEYV, 8'h01}, "R2");
        rd(A_MODE, "R4");

        // R5: config refused, other groups open (R6 independence)
        wr(8'h20, 32'h5, "R5");
        wr(8'h00, 32'h5, "R6");
        wr(8'h14, 32'h5, "R6");
        rd(A_STAT, "R7");
        rd(A_STAT, "R11");

        // R8: latest record kept, pulse only first (R10)
        wr(A_MODE, {KEYV, 8'h07}, "R2");
        wr(8'h30, 32'h1, "R10");
        wr(8'h10, 32'h1, "R8");
        wr(8'h00, 32'h1, "R8");
        idle("R10");
        rd(A_STAT, "R8");

        // R9: first record kept
        wr(A_MODE, {KEYV, 8'h17}, "R9");
        wr(8'h14, 32'h1, "R9");
        wr(8'h24, 32'h1, "R9");
        wr(8'h00, 32'h1, "R9");
        // R12: status write ignored
        wr(A_STAT, 32'hFFFF_FFFF, "R12");
        rd(A_STAT, "R9");
        idle("R11");
        // rebuild a series, then collide read with a new violation
        wr(8'h18, 32'h1, "R10");
        cyc(1, 8'h00, 32'h1, 1, A_STAT, "R11");
        idle("R11");
        rd(A_STAT, "R11");
        rd(A_MODE, "R4");

        // disable: wrong key keeps enables, right key clears
        wr(A_MODE, 32'h12345600, "R2");
        rd(A_MODE, "R2");
        wr(A_MODE, {KEYV, 8'h00}, "R2");
        wr(8'h20, 32'h1, "R2");
        wr(8'h00, 32'h1, "R6");

        // randomised phase, compared every clock
        for (int i = 0; i < 600; i++) begin
            bit [7:0]  wa = pool[$urandom_range(0, 6)];
            bit [7:0]  ra = pool[$urandom_range(0, 6)];
            bit [31:0] d = $urandom;
            if (wa == A_MODE && $urandom_range(0, 2) != 0) d[31:8] = KEYV;
            cyc(1'($urandom_range(0, 1)), wa, d, 1'($urandom_range(0, 2) == 0), ra, "R11");
        end
        idle("R12");
        idle("R12");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule